// File: doc/BRIEF.md
# Clock Crossbar Output Channel with Cascaded Gated Dividers

This block forms one output of a clock generator. A crossbar field picks one of up to `NSRC` parent clocks, and the chosen clock then runs through two divider stages in series. The first is a pre-divider with a 10-bit ratio. The second is a final divider with a 6-bit ratio. Each stage has its own enable gate. The output rate is the parent rate divided by (pre ratio + 1) and then by (final ratio + 1).

All logic runs on one system clock `clk`. The parents arrive as level signals in the `clk` domain. Each rising edge of the selected parent counts as one input tick. `clk_out` carries the divided clock as a stream of one-cycle pulses, with one pulse per output period.

Software controls the block through a flat word register port. One 32-bit crossbar word is shared by four channels, and each channel owns one byte lane of it. This channel also has its own pre-divider word and its own final-divider word. Software turns the output on by setting the pre-divider gate first and then the final gate. To turn the output off, it clears only the final gate.

Top module: `clkxbar_chan`

## Requirements
- R1: Out of reset every field reads zero (source 0, both gates off, both ratios zero), and `clk_out` and `chan_active` are low.
- R2: The crossbar word sits at byte address `XBAR_BASE + 4*(CHAN_IDX/4)`. Each of its four byte lanes stores bits 6:0, and bit 7 of every lane reads zero. This channel uses lane `CHAN_IDX%4`: bits 5:0 select the source and bit 6 is the pre-divider gate. The other lanes are kept and read back unchanged.
- R3: The pre-divider word at `PDIV_BASE + 4*CHAN_IDX` holds its ratio in bits 9:0. The final word at `FDIV_BASE + 4*CHAN_IDX` holds its ratio in bits 5:0 and the final gate in bit 6. All other bits read zero. A write to any other address leaves these words unchanged.
- R4: A source select below `NSRC` picks that parent. A select of `NSRC` or above picks a constant low, so no output pulses appear.
- R5: With both gates on, the spacing of `clk_out` pulses in steady state is Psrc·(P+1)·(F+1) cycles, where Psrc is the parent period and P and F are the two ratio fields.
- R6: When both ratios are zero, the output pulse spacing equals the parent period.
- R7: While the pre-divider gate is off, no output pulses appear, whatever the state of the final gate.
- R8: While the final gate is off, `clk_out` stays low. `chan_active` always equals the final gate bit and ignores the pre-divider gate.
- R9: A stage that is off holds its counter at zero. After the final gate is set, the first output pulse appears only after F+1 pre-divider ticks.
- R10: A ratio written in the middle of a period does not change that period. It takes effect from the next terminal count.
- R11: Each `clk_out` pulse is exactly one `clk` cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | NSRC | Parent clocks, sampled in the clk domain |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for reg_addr; unmapped addresses read zero |
| clk_out | output | 1 | Divided output, one pulse per period |
| chan_active | output | 1 | Final gate state |

## Verification
Some rules hold cycle by cycle, and the assertions check them on every cycle:
- a cleared gate blocks its stage;
- every output pulse follows a pre-divider tick;
- pulses are one cycle wide;
- outputs stay quiet during reset.

The remaining properties can only be seen over whole periods, so the directed scenarios cover them:
- the exact pulse spacing for several sources and ratio pairs;
- the delay to the first pulse after enabling;
- a retune in the middle of a period taking effect only at the period boundary;
- the packing, masking and isolation of the shared crossbar lanes.

// File: rtl/clkxbar_pkg.sv
package clkxbar_pkg;
  localparam int DATA_W    = 32;
  localparam int LANES     = 4;
  localparam int LANE_W    = DATA_W / LANES;
  localparam int SEL_W     = 6;
  localparam int GATE_BIT  = 6;
  localparam int LANE_USED = GATE_BIT + 1;
  localparam int PDIV_W    = 10;
  localparam int FDIV_W    = 6;
endpackage

// File: rtl/clkxbar_regs.sv
module clkxbar_regs
  import clkxbar_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CHAN_IDX  = 1,
  parameter int XBAR_BASE = 'h020,
  parameter int PDIV_BASE = 'h060,
  parameter int FDIV_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SEL_W-1:0]  src_sel,
  output logic              pre_en,
  output logic [PDIV_W-1:0] pre_ratio,
  output logic              fin_en,
  output logic [FDIV_W-1:0] fin_ratio
);
  localparam int MY_LANE = CHAN_IDX % LANES;
  localparam logic [ADDR_W-1:0] XBAR_ADDR = ADDR_W'(XBAR_BASE + (CHAN_IDX / LANES) * 4);
  localparam logic [ADDR_W-1:0] PDIV_ADDR = ADDR_W'(PDIV_BASE + CHAN_IDX * 4);
  localparam logic [ADDR_W-1:0] FDIV_ADDR = ADDR_W'(FDIV_BASE + CHAN_IDX * 4);

  logic [LANE_USED-1:0] lane_q [LANES];
  logic [LANE_USED-1:0] lane_d [LANES];
  logic [PDIV_W-1:0]    pdiv_q, pdiv_d;
  logic [FDIV_W-1:0]    fdiv_q, fdiv_d;
  logic                 fgate_q, fgate_d;
  logic                 hit_xbar, hit_pdiv, hit_fdiv;
  logic [DATA_W-1:0]    xbar_word;
  logic                 unused_wbits;

  assign hit_xbar = wr_en && (addr == XBAR_ADDR);
  assign hit_pdiv = wr_en && (addr == PDIV_ADDR);
  assign hit_fdiv = wr_en && (addr == FDIV_ADDR);

  // next state
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_d[i] = hit_xbar ? wdata[i*LANE_W +: LANE_USED] : lane_q[i];
    end
    pdiv_d  = hit_pdiv ? wdata[PDIV_W-1:0] : pdiv_q;
    fdiv_d  = hit_fdiv ? wdata[FDIV_W-1:0] : fdiv_q;
    fgate_d = hit_fdiv ? wdata[GATE_BIT]   : fgate_q;
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
      pdiv_q  <= '0;
      fdiv_q  <= '0;
      fgate_q <= 1'b0;
    end else begin
      for (int i = 0; i < LANES; i++) lane_q[i] <= lane_d[i];
      pdiv_q  <= pdiv_d;
      fdiv_q  <= fdiv_d;
      fgate_q <= fgate_d;
    end
  end

  // shared word assembly for readback
  for (genvar g = 0; g < LANES; g++) begin : g_lane_rd
    assign xbar_word[g*LANE_W +: LANE_W] = LANE_W'(lane_q[g]);
  end

  always_comb begin
    rdata = '0;
    if (addr == XBAR_ADDR) begin
      rdata = xbar_word;
    end else if (addr == PDIV_ADDR) begin
      rdata[PDIV_W-1:0] = pdiv_q;
    end else if (addr == FDIV_ADDR) begin
      rdata[FDIV_W-1:0] = fdiv_q;
      rdata[GATE_BIT]   = fgate_q;
    end
  end

  assign src_sel   = lane_q[MY_LANE][SEL_W-1:0];
  assign pre_en    = lane_q[MY_LANE][GATE_BIT];
  assign pre_ratio = pdiv_q;
  assign fin_en    = fgate_q;
  assign fin_ratio = fdiv_q;

  assign unused_wbits = ^{wdata[31], wdata[23], wdata[15], wdata[7]};
endmodule

// File: rtl/clkxbar_srcsel.sv
module clkxbar_srcsel
  import clkxbar_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic pick;
  logic smp_q, dly_q;

  // out-of-range selects fall through to constant low
  always_comb begin
    pick = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (sel == SEL_W'(k)) pick = src[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      dly_q <= 1'b0;
    end else begin
      smp_q <= pick;
      dly_q <= smp_q;
    end
  end

  assign tick = smp_q & ~dly_q;
endmodule

// File: rtl/clkxbar_div.sv
module clkxbar_div #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick_in,
  input  logic [W-1:0] ratio,
  output logic         tick_out
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] act_q, act_d;
  logic         out_d;
  logic         at_term;

  assign at_term = (cnt_q == act_q);

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    out_d = 1'b0;
    if (!en) begin
      cnt_d = '0;
      act_d = ratio;
    end else if (tick_in) begin
      if (at_term) begin
        cnt_d = '0;
        act_d = ratio;
        out_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      act_q    <= '0;
      tick_out <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      act_q    <= act_d;
      tick_out <= out_d;
    end
  end
endmodule

// File: rtl/clkxbar_chan.sv
module clkxbar_chan
  import clkxbar_pkg::*;
#(
  parameter int NSRC      = 8,
  parameter int ADDR_W    = 12,
  parameter int CHAN_IDX  = 1,
  parameter int XBAR_BASE = 'h020,
  parameter int PDIV_BASE = 'h060,
  parameter int FDIV_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_clk,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  output logic              clk_out,
  output logic              chan_active
);
  logic              rst_meta_q, rst_sync_n;
  logic [SEL_W-1:0]  src_sel;
  logic              pre_en, fin_en;
  logic [PDIV_W-1:0] pre_ratio;
  logic [FDIV_W-1:0] fin_ratio;
  logic              src_tick, pre_tick;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  clkxbar_regs #(
    .ADDR_W(ADDR_W), .CHAN_IDX(CHAN_IDX),
    .XBAR_BASE(XBAR_BASE), .PDIV_BASE(PDIV_BASE), .FDIV_BASE(FDIV_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .src_sel(src_sel),
    .pre_en(pre_en), .pre_ratio(pre_ratio), .fin_en(fin_en), .fin_ratio(fin_ratio)
  );

  clkxbar_srcsel #(.NSRC(NSRC)) u_sel (
    .clk(clk), .rst_n(rst_sync_n), .src(src_clk), .sel(src_sel), .tick(src_tick)
  );

  clkxbar_div #(.W(PDIV_W)) u_pdiv (
    .clk(clk), .rst_n(rst_sync_n), .en(pre_en), .tick_in(src_tick),
    .ratio(pre_ratio), .tick_out(pre_tick)
  );

  clkxbar_div #(.W(FDIV_W)) u_fdiv (
    .clk(clk), .rst_n(rst_sync_n), .en(fin_en), .tick_in(pre_tick),
    .ratio(fin_ratio), .tick_out(clk_out)
  );

  assign chan_active = fin_en;
endmodule

// File: rtl/clkxbar_chan_chk.sv
module clkxbar_chan_chk (
  input logic clk,
  input logic rst_n,
  input logic pre_en,
  input logic pre_tick,
  input logic clk_out,
  input logic chan_active
);
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      assert_quiet_in_reset_R1: assert (clk_out == 1'b0 && chan_active == 1'b0)
        else $error("output active during reset");
    end
  end

  assert_pre_gate_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |=> !pre_tick);

  assert_final_gate_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_active |=> !clk_out);

  assert_out_after_pretick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> $past(pre_tick));

  assert_single_cycle_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |=> !clk_out);
endmodule

bind clkxbar_chan clkxbar_chan_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pre_en(pre_en), .pre_tick(pre_tick),
  .clk_out(clk_out), .chan_active(chan_active)
);

// File: tb/sim_clkxbar_chan.sv
`timescale 1ns/1ps
module sim_clkxbar_chan;
  localparam int NSRC = 8;
  localparam logic [11:0] XA  = 12'h020;
  localparam logic [11:0] PA  = 12'h064;
  localparam logic [11:0] FA  = 12'h104;
  localparam logic [11:0] PA2 = 12'h068;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_clk = '0;
  logic [11:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic            reg_we = 1'b0;
  logic [31:0]     reg_rdata;
  logic            clk_out, chan_active;
  int              cyc = 0;
  int              checks = 0;
  int              errors = 0;

  always #2.5 clk = ~clk;

  clkxbar_chan #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .clk_out(clk_out), .chan_active(chan_active)
  );

  function automatic int per(int k);
    return 4 + 2 * k;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int k = 0; k < NSRC; k++) src_clk[k] <= ((cyc % per(k)) < per(k) / 2);
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] xword(input int sel, input bit pg);
    return {8'hFF, 8'h3C, 1'b1, pg, 6'(sel), 8'h5A};
  endfunction

  task automatic cfg(input int sel, input bit pg, input int p, input bit fg, input int f);
    wr(XA, xword(sel, pg));
    wr(PA, 32'(p));
    wr(FA, {25'd0, fg, 6'(f)});
  endtask

  task automatic wait_pulse(output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (clk_out) begin t = cyc; break; end
    end
  endtask

  task automatic steady_gap(output int g);
    int a, b;
    wait_pulse(a); wait_pulse(a); wait_pulse(b);
    g = (a < 0 || b < 0) ? -1 : b - a;
  endtask

  task automatic count_pulses(input int n, output int np, output int dbl);
    logic prev = 1'b0;
    np = 0; dbl = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_out) np++;
      if (clk_out && prev) dbl++;
      prev = clk_out;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    int np, dbl;
    rd(XA, d); check("R1 crossbar reset", d, 0);
    rd(PA, d); check("R1 pre ratio reset", d, 0);
    rd(FA, d); check("R1 final word reset", d, 0);
    check("R1 chan_active reset", chan_active, 0);
    count_pulses(60, np, dbl);
    check("R1 no output after reset", np, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(XA, xword(5, 1'b1));
    rd(XA, d); check("R2 lane packing and bit7 mask", d, 32'h7F3C455A);
    wr(PA, 32'hFFFF_FFFF);
    rd(PA, d); check("R3 pre ratio mask", d, 32'h3FF);
    wr(FA, 32'hFFFF_FFFF);
    rd(FA, d); check("R3 final word mask", d, 32'h7F);
    check("R8 chan_active from final gate", chan_active, 1);
    wr(PA2, 32'h0000_0012);
    rd(PA, d); check("R3 foreign address ignored", d, 32'h3FF);
    rd(PA2, d); check("R3 unmapped reads zero", d, 0);
    wr(FA, 32'h0);
    check("R8 chan_active cleared", chan_active, 0);
  endtask

  task automatic t_pass;
    int g, np, dbl;
    cfg(0, 1'b1, 0, 1'b1, 0);
    steady_gap(g); check("R6 passthrough period src0", g, per(0));
    count_pulses(200, np, dbl);
    check("R11 no double-wide pulse", dbl, 0);
    check("R6 pulse count in 200 cycles", np, 200 / per(0));
  endtask

  task automatic t_rate;
    int g;
    cfg(2, 1'b1, 2, 1'b1, 1);
    steady_gap(g); check("R5 src2 p2 f1", g, per(2) * 3 * 2);
    cfg(5, 1'b1, 1, 1'b1, 2);
    steady_gap(g); check("R5 src5 p1 f2", g, per(5) * 2 * 3);
    cfg(1, 1'b1, 3, 1'b1, 0);
    steady_gap(g); check("R4 src1 selected p3", g, per(1) * 4);
  endtask

  task automatic t_badsel;
    int np, dbl, g;
    cfg(NSRC, 1'b1, 0, 1'b1, 0);
    count_pulses(300, np, dbl); check("R4 select equal NSRC silent", np, 0);
    cfg(63, 1'b1, 0, 1'b1, 0);
    count_pulses(300, np, dbl); check("R4 select 63 silent", np, 0);
    cfg(7, 1'b1, 0, 1'b1, 0);
    steady_gap(g); check("R4 top valid source", g, per(7));
  endtask

  task automatic t_gates;
    int np, dbl;
    cfg(0, 1'b1, 1, 1'b0, 1);
    count_pulses(300, np, dbl);
    check("R8 final gate off no output", np, 0);
    check("R8 chan_active off", chan_active, 0);
    cfg(0, 1'b0, 1, 1'b1, 1);
    count_pulses(300, np, dbl);
    check("R7 pre gate off no output", np, 0);
    check("R8 chan_active ignores pre gate", chan_active, 1);
  endtask

  task automatic t_first;
    int tw, t1, d;
    cfg(0, 1'b1, 0, 1'b0, 3);
    repeat (50) @(negedge clk);
    tw = cyc;
    wr(FA, {25'd0, 1'b1, 6'd3});
    wait_pulse(t1);
    d = t1 - tw;
    check("R9 first pulse not early", (d > 3 * per(0)) ? 1 : 0, 1);
    check("R9 first pulse not late", (d <= 4 * per(0) + 4) ? 1 : 0, 1);
  endtask

  task automatic t_retune;
    int t0, t1, t2;
    cfg(0, 1'b1, 0, 1'b1, 3);
    wait_pulse(t0); wait_pulse(t0);
    reg_addr = FA; reg_wdata = {25'd0, 1'b1, 6'd1}; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    wait_pulse(t1); wait_pulse(t2);
    check("R10 current period kept", t1 - t0, per(0) * 4);
    check("R10 new ratio after terminal", t2 - t1, per(0) * 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_regs();
    t_pass();
    t_rate();
    t_badsel();
    t_gates();
    t_first();
    t_retune();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule